// File: doc/BRIEF.md
# Dual Wiper Step Command Unit

This block holds the settings of two digital potentiometer wipers and changes them with a small set of fixed adjustment commands. Two commands are linear: one step up and one step down. The other two are logarithmic. A +6 dB step doubles the setting and a −6 dB step halves it. The block carries out the doubling and halving as one-bit shifts, and it clamps the result at the ends of the range.

A command arrives as a 2-bit operation code, a 2-bit channel mask and a one-cycle valid strobe. The mask can select either wiper alone or both wipers together. When both are selected, the two settings update on the same clock edge, each starting from its own current value. Both wiper settings are always driven on output ports, so they can be read back. A done pulse marks the cycle in which the new settings first appear. The resolution is a parameter. It is 6 bits (64 positions) or 8 bits (256 positions). The reset setting is mid-scale.

Top module: `dual_wiper_step`

## Requirements
- R1: While reset is held, and after it is released with no command given, both wipers read mid-scale 2^(W-1) and cmd_done is 0.
- R2: Operation code 2'b00 (increment) adds 1 to each selected wiper. A wiper already at full scale 2^W-1 stays there.
- R3: Operation code 2'b01 (decrement) subtracts 1 from each selected wiper. A wiper already at 0 stays at 0.
- R4: Operation code 2'b10 (+6 dB) shifts each selected wiper left by one bit. A setting of 0 becomes 1, and a setting with its top bit set becomes full scale.
- R5: Operation code 2'b11 (−6 dB) shifts each selected wiper right by one bit, truncating toward zero, so 1 becomes 0 and 0 stays 0.
- R6: cmd_sel bit 0 selects wiper A and bit 1 selects wiper B. A wiper that is not selected keeps its value, and a mask of 2'b00 changes neither wiper.
- R7: With cmd_sel = 2'b11, both wipers take their new values on the same clock edge, each computed from its own prior value.
- R8: A command sampled with cmd_valid high at a rising edge is visible on the wiper outputs immediately after that edge. cmd_done is high for exactly that following cycle, once per accepted command.
- R9: While cmd_valid is low, neither wiper changes and cmd_done stays low, whatever cmd_op and cmd_sel hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | One cycle per command |
| cmd_op | input | 2 | Operation: 00 up, 01 down, 10 double, 11 halve |
| cmd_sel | input | 2 | Channel mask: bit 0 wiper A, bit 1 wiper B |
| wiper_a | output | WIPER_W | Current setting of wiper A |
| wiper_b | output | WIPER_W | Current setting of wiper B |
| cmd_done | output | 1 | High for the cycle after an accepted command |

## Verification
Every result arrives one register stage after the edge that samples cmd_valid. The new wiper values and the cmd_done pulse both appear in the cycle after the command edge, so no result is due later than that cycle. The driver applies each command at a falling edge and records the expected pair of wiper values. The monitor samples at the next falling edge, where cmd_done must be high and must match a queued entry. Any cmd_done with no entry queued, or any entry still pending when the run ends, counts as a failure, and that is how idle cycles and empty masks are held to the rule of no effect.

// File: rtl/wiper_step_pkg.sv
package wiper_step_pkg;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic [1:0] {
    OP_INC  = 2'b00,
    OP_DEC  = 2'b01,
    OP_DBL  = 2'b10,
    OP_HALF = 2'b11
  } step_op_e;
endpackage

// File: rtl/wiper_step_alu.sv
module wiper_step_alu
  import wiper_step_pkg::*;
#(
  parameter int unsigned WIPER_W = 8
) (
  input  logic [WIPER_W-1:0] cur,
  input  step_op_e           op,
  output logic [WIPER_W-1:0] nxt
);
  localparam logic [WIPER_W-1:0] FULL = {WIPER_W{1'b1}};
  localparam logic [WIPER_W-1:0] ZERO = '0;
  localparam logic [WIPER_W-1:0] ONE  = {{(WIPER_W-1){1'b0}}, 1'b1};

  always_comb begin
    nxt = cur;
    unique case (op)
      OP_INC:  nxt = (cur == FULL) ? FULL : cur + ONE;
      OP_DEC:  nxt = (cur == ZERO) ? ZERO : cur - ONE;
      OP_DBL: begin
        if (cur == ZERO)          nxt = ONE;
        else if (cur[WIPER_W-1])  nxt = FULL;
        else                      nxt = {cur[WIPER_W-2:0], 1'b0};
      end
      OP_HALF: nxt = {1'b0, cur[WIPER_W-1:1]};
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/wiper_step_sel.sv
module wiper_step_sel #(
  parameter int unsigned NCH = 2
) (
  input  logic           valid,
  input  logic [NCH-1:0] sel,
  output logic [NCH-1:0] en
);
  for (genvar i = 0; i < NCH; i++) begin : g_en
    assign en[i] = valid & sel[i];
  end
endmodule

// File: rtl/wiper_chan.sv
module wiper_chan
  import wiper_step_pkg::*;
#(
  parameter int unsigned WIPER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_en,
  input  step_op_e           op,
  output logic [WIPER_W-1:0] q
);
  localparam logic [WIPER_W-1:0] MID = {1'b1, {(WIPER_W-1){1'b0}}};

  logic [WIPER_W-1:0] stepped;
  logic [WIPER_W-1:0] q_d;

  wiper_step_alu #(.WIPER_W(WIPER_W)) u_alu (
    .cur (q),
    .op  (op),
    .nxt (stepped)
  );

  always_comb begin
    q_d = q;
    if (upd_en) q_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= MID;
    else        q <= q_d;
  end
endmodule

// File: rtl/dual_wiper_step.sv
module dual_wiper_step
  import wiper_step_pkg::*;
#(
  parameter int unsigned WIPER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [1:0]         cmd_sel,
  output logic [WIPER_W-1:0] wiper_a,
  output logic [WIPER_W-1:0] wiper_b,
  output logic               cmd_done
);
  logic [NUM_CH-1:0]  ch_en;
  logic [WIPER_W-1:0] ch_q [NUM_CH];
  step_op_e           op_e;
  logic               done_d;

  assign op_e = step_op_e'(cmd_op);

  wiper_step_sel #(.NCH(NUM_CH)) u_sel (
    .valid (cmd_valid),
    .sel   (cmd_sel),
    .en    (ch_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wiper_chan #(.WIPER_W(WIPER_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_en (ch_en[c]),
      .op     (op_e),
      .q      (ch_q[c])
    );
  end

  assign wiper_a = ch_q[0];
  assign wiper_b = ch_q[1];

  always_comb done_d = cmd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_done <= 1'b0;
    else        cmd_done <= done_d;
  end
endmodule

// File: rtl/dual_wiper_step_chk.sv
module dual_wiper_step_chk #(
  parameter int unsigned WIPER_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [1:0]         cmd_op,
  input logic [1:0]         cmd_sel,
  input logic [WIPER_W-1:0] wiper_a,
  input logic [WIPER_W-1:0] wiper_b,
  input logic               cmd_done
);
  localparam logic [WIPER_W-1:0] FULL = {WIPER_W{1'b1}};
  localparam logic [WIPER_W-1:0] ONE  = {{(WIPER_W-1){1'b0}}, 1'b1};

  a_r2_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_sel[0] && cmd_op == 2'b00 && wiper_a != FULL)
      |=> wiper_a == $past(wiper_a) + ONE);

  a_r2_inc_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b00 && wiper_a == FULL) |=> wiper_a == FULL);

  a_r3_dec_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01 && wiper_b == '0) |=> wiper_b == '0);

  a_r4_dbl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_sel[1] && cmd_op == 2'b10 && wiper_b == '0) |=> wiper_b == ONE);

  a_r5_half: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_sel[0] && cmd_op == 2'b11) |=> wiper_a == ($past(wiper_a) >> 1));

  a_r6_a_unsel: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_sel[0]) |=> $stable(wiper_a));

  a_r6_b_unsel: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_sel[1]) |=> $stable(wiper_b));

  a_r8_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> cmd_done);

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !cmd_done);
endmodule

bind dual_wiper_step dual_wiper_step_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_sel   (cmd_sel),
  .wiper_a   (wiper_a),
  .wiper_b   (wiper_b),
  .cmd_done  (cmd_done)
);

// File: tb/dual_wiper_step_tb.sv
module dual_wiper_step_tb;
  localparam int W = 8;
  localparam int FULL = (1 << W) - 1;
  localparam int MID = 1 << (W - 1);

  typedef struct {
    int    a;
    int    b;
    string tag;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic         cmd_valid;
  logic [1:0]   cmd_op;
  logic [1:0]   cmd_sel;
  logic [W-1:0] wiper_a;
  logic [W-1:0] wiper_b;
  logic         cmd_done;

  int checks = 0;
  int failures = 0;
  int model_a;
  int model_b;
  exp_t sb[$];

  dual_wiper_step #(.WIPER_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .wiper_a(wiper_a), .wiper_b(wiper_b), .cmd_done(cmd_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int step(int v, logic [1:0] op);
    case (op)
      2'b00: return (v == FULL) ? FULL : v + 1;
      2'b01: return (v == 0) ? 0 : v - 1;
      2'b10: return (v == 0) ? 1 : ((v * 2 > FULL) ? FULL : v * 2);
      default: return v / 2;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [1:0] sel, string tag);
    if (sel[0]) model_a = step(model_a, op);
    if (sel[1]) model_b = step(model_b, op);
    sb.push_back('{a: model_a, b: model_b, tag: tag});
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_sel = sel;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(int'(wiper_a) == e.a, {e.tag, " wiper_a"}, int'(wiper_a), e.a);
          check(int'(wiper_b) == e.b, {e.tag, " wiper_b"}, int'(wiper_b), e.b);
        end
      end
    end
  end

  initial begin
    cmd_valid = 1'b0;
    cmd_op = 2'b00;
    cmd_sel = 2'b00;
    rst_n = 1'b0;
    model_a = MID;
    model_b = MID;
    fork
      begin
        repeat (3) @(negedge clk);
        check(int'(wiper_a) == MID, "R1 reset wiper_a", int'(wiper_a), MID);
        check(int'(wiper_b) == MID, "R1 reset wiper_b", int'(wiper_b), MID);
        check(cmd_done == 1'b0, "R1 reset done", int'(cmd_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(wiper_a) == MID, "R1 after release", int'(wiper_a), MID);

        issue(2'b00, 2'b01, "R2 inc A");
        for (int i = 0; i < 130; i++) issue(2'b00, 2'b01, "R2 inc A to sat");
        for (int i = 0; i < 130; i++) issue(2'b01, 2'b10, "R3 dec B to zero");
        issue(2'b01, 2'b10, "R3 dec B at zero");
        issue(2'b10, 2'b10, "R4 double zero");
        for (int i = 0; i < 7; i++) issue(2'b10, 2'b10, "R4 double B");
        issue(2'b10, 2'b10, "R4 double top bit");
        issue(2'b10, 2'b01, "R4 double at full");
        issue(2'b11, 2'b01, "R5 halve A");
        issue(2'b11, 2'b01, "R5 halve A odd");
        issue(2'b00, 2'b00, "R6 empty mask");
        issue(2'b01, 2'b10, "R6 B only");
        issue(2'b11, 2'b11, "R7 both halve");
        issue(2'b00, 2'b11, "R7 both inc");
        for (int i = 0; i < 9; i++) issue(2'b11, 2'b11, "R5 halve to zero");
        issue(2'b11, 2'b11, "R5 halve zero");
        // R8: back-to-back commands, one done each
        issue(2'b10, 2'b11, "R8 back to back 1");
        issue(2'b10, 2'b11, "R8 back to back 2");
        // R9: idle with live-looking op/sel
        cmd_op = 2'b00;
        cmd_sel = 2'b11;
        repeat (5) @(negedge clk);
        check(int'(wiper_a) == model_a, "R9 idle wiper_a", int'(wiper_a), model_a);
        check(int'(wiper_b) == model_b, "R9 idle wiper_b", int'(wiper_b), model_b);
        check(sb.size() == 0, "R8 pending results", sb.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule